// File: doc/BRIEF.md
# Command Queue Front End with Mode-Aware Decode

This block is the command-register front end of a storage-bus controller. Software writes 8-bit command bytes into a queue with two entries. When a command reaches the head of an otherwise idle queue it is launched at once. At launch the block checks whether the code is legal for the current operating mode (disconnected, initiator or target) and for the chip variant chosen by a parameter. A legal command produces a start strobe for the sequencers behind this block. An illegal one produces an illegal-command event.

Three legal codes finish on their own and let the next queued command follow: no-op, FIFO flush and set-attention. Every other command stays at the head until the status logic pulses `pop_i`. The two reset codes do not wait in the queue. They empty it and fire their strobe as soon as they are written. A write that finds both entries occupied is thrown away and raises a gross-error event.

Top module: `cmdq_front`

## Requirements
- R1: After reset every strobe output is low, `cmd_o` is zero and `q_count_o` is 0.
- R2: A write captured at clock edge N into an empty queue gives `q_count_o` = 1 after edge N. The launch result (`start_o` or `illegal_o`, with `cmd_o` showing the byte) is present for exactly one cycle after edge N+1.
- R3: Legality uses code bits 6:0. The group is bits 6:4 and the sub-code is bits 3:0. Mode encoding is 0 = disconnected, 1 = initiator, 2 = target. In the base variant (ENHANCED = 0): group 0 is legal in every mode for sub-codes 0–3. Group 1 is legal only in initiator mode, for sub-codes 0, 1, 2, 8 and 10. Group 2 is legal only in target mode, for sub-codes 0–11 except 6. Group 4 is legal only in disconnected mode, for sub-codes 0–5. All other groups are illegal.
- R4: With ENHANCED = 1, three extra codes are legal: sub-code 4 of group 0 in target mode, sub-code 6 of group 4 in disconnected mode, and sub-code 11 of group 1 in initiator mode.
- R5: An illegal head gives `illegal_o` and no `start_o`. It stays queued until `pop_i` removes it.
- R6: The queue holds at most two commands. A write that finds two entries after any pop in the same cycle is discarded: `gross_err_o` pulses after that edge and `q_count_o` stays 2. This also applies to the reset codes.
- R7: `pop_i` removes a launched head. If a second entry exists, it becomes the head and is launched one edge later. `pop_i` has no effect on an empty queue or on a head that has not yet launched.
- R8: Writing code 0x02 (chip reset) or 0x03 (bus reset) into a non-full queue empties it in the same edge and pulses `chip_rst_o` or `bus_rst_o` after that edge. A head due to launch at that edge produces no strobe.
- R9: Legal codes 0x00 (no-op) and 0x01 (flush) pulse `start_o` and leave the queue on their own, so the next entry launches one edge later. Code 0x01 also pulses `flush_o` together with `start_o`.
- R10: Code 0x1A is legal only in initiator mode. There it pulses `atn_o` together with `start_o` and leaves the queue on its own.
- R11: Bit 7 of the command plays no part in decoding and is passed through unchanged on `cmd_o`.
- R12: Legality is judged on `mode_i` as sampled at the launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode: 0 disconnected, 1 initiator, 2 target |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 8 | Command byte |
| pop_i | input | 1 | Head finished, from the status block |
| start_o | output | 1 | Legal head launched |
| illegal_o | output | 1 | Illegal head seen at launch |
| cmd_o | output | 8 | Launched byte, valid with start_o or illegal_o |
| gross_err_o | output | 1 | Write to a full queue discarded |
| chip_rst_o | output | 1 | Chip-reset command accepted |
| bus_rst_o | output | 1 | Bus-reset command accepted |
| flush_o | output | 1 | Clear FIFO occupancy |
| atn_o | output | 1 | Assert attention line |
| q_count_o | output | 2 | Commands held in the queue |

## Verification
The assertions assume that `mode_i` is stable around launch edges and that it only takes the three defined encodings. They also assume `pop_i` is a single-cycle pulse from a status block that has seen a launch. The stimulus changes the mode only while the queue is idle. It pulses `pop_i` one cycle at a time, from negative edges only, sometimes against an empty queue on purpose. It also issues back-to-back writes to exercise chaining, overflow and reset preemption. Expected events come from a legality model written from the requirements and are compared in order by a scoreboard for each variant.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int unsigned CMD_W  = 8;
    localparam int unsigned CODE_W = CMD_W - 1;
    localparam int unsigned QDEPTH = 2;
    localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_INIT = 2'd1,
        MODE_TARG = 2'd2,
        MODE_RSVD = 2'd3
    } op_mode_e;

    localparam logic [CODE_W-1:0] OP_NOP     = 7'h00;
    localparam logic [CODE_W-1:0] OP_FLUSH   = 7'h01;
    localparam logic [CODE_W-1:0] OP_CHIPRST = 7'h02;
    localparam logic [CODE_W-1:0] OP_BUSRST  = 7'h03;
    localparam logic [CODE_W-1:0] OP_SETATN  = 7'h1A;

    typedef struct packed {
        logic             start;
        logic             illegal;
        logic             gross;
        logic             chip_rst;
        logic             bus_rst;
        logic             flush;
        logic             atn;
        logic [CMD_W-1:0] cmd;
    } evt_t;

endpackage

// File: rtl/cmdq_legal.sv
module cmdq_legal
    import cmdq_pkg::*;
#(
    parameter bit ENHANCED = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        mode_i,
    output logic              legal_o,
    output logic              self_done_o,
    output logic              is_flush_o,
    output logic              is_atn_o
);

    localparam logic [3:0] G4_LAST = ENHANCED ? 4'd6 : 4'd5;

    logic [2:0] grp;
    logic [3:0] sub;
    op_mode_e   md;

    assign grp = code_i[6:4];
    assign sub = code_i[3:0];
    assign md  = op_mode_e'(mode_i);

    always_comb begin
        legal_o = 1'b0;
        case (grp)
            3'd0: legal_o = (sub <= 4'd3) ||
                            (ENHANCED && md == MODE_TARG && sub == 4'd4);
            3'd1: legal_o = (md == MODE_INIT) &&
                            ((sub <= 4'd2) || sub == 4'd8 || sub == 4'd10 ||
                             (ENHANCED && sub == 4'd11));
            3'd2: legal_o = (md == MODE_TARG) && (sub <= 4'd11) && (sub != 4'd6);
            3'd4: legal_o = (md == MODE_IDLE) && (sub <= G4_LAST);
            default: legal_o = 1'b0;
        endcase
    end

    always_comb begin
        is_flush_o  = (code_i == OP_FLUSH);
        is_atn_o    = (code_i == OP_SETATN);
        self_done_o = legal_o && (code_i == OP_NOP || is_flush_o || is_atn_o);
    end

endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
    import cmdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CMD_W-1:0] wr_data_i,
    input  logic             ext_pop_i,
    input  logic             self_pop_i,
    output logic [CMD_W-1:0] head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             acc_chip_o,
    output logic             acc_bus_o,
    output logic             drop_full_o
);

    typedef struct packed {
        logic [QDEPTH-1:0][CMD_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
        logic                         pend;
    } st_t;

    st_t st_d, st_q;
    logic pop_ok, is_rst, rst_acc;

    always_comb begin
        st_d        = st_q;
        st_d.pend   = 1'b0;
        pop_ok      = self_pop_i ||
                      (ext_pop_i && !st_q.pend && st_q.cnt != '0);
        is_rst      = (wr_data_i[CODE_W-1:0] == OP_CHIPRST) ||
                      (wr_data_i[CODE_W-1:0] == OP_BUSRST);
        drop_full_o = 1'b0;
        rst_acc     = 1'b0;

        if (pop_ok) begin
            for (int i = 0; i < QDEPTH - 1; i++) begin
                st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.pend = (st_d.cnt != '0);
        end

        if (wr_en_i) begin
            if (st_d.cnt == CNT_W'(QDEPTH)) begin
                drop_full_o = 1'b1;
            end else if (is_rst) begin
                rst_acc   = 1'b1;
                st_d.cnt  = '0;
                st_d.pend = 1'b0;
            end else begin
                st_d.ent[st_d.cnt[0]] = wr_data_i;
                if (st_d.cnt == '0) begin
                    st_d.pend = 1'b1;
                end
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end

        acc_chip_o = rst_acc && (wr_data_i[CODE_W-1:0] == OP_CHIPRST);
        acc_bus_o  = rst_acc && (wr_data_i[CODE_W-1:0] == OP_BUSRST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o = st_q.ent[0];
    assign cnt_o  = st_q.cnt;
    assign pend_o = st_q.pend;

    // R6: occupancy never exceeds the queue depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(QDEPTH));

    // R6: a write to a full queue with no pop leaves contents untouched
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && st_q.cnt == CNT_W'(QDEPTH) && !ext_pop_i && !self_pop_i)
        |=> (st_q.cnt == CNT_W'(QDEPTH) && $stable(st_q.ent)));

    // R8: an accepted reset code leaves an empty, idle queue
    assert_reset_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && st_q.cnt < CNT_W'(QDEPTH) &&
         (wr_data_i[CODE_W-1:0] == OP_CHIPRST || wr_data_i[CODE_W-1:0] == OP_BUSRST))
        |=> (st_q.cnt == '0 && !st_q.pend));

    // R7: a pending launch always has a head behind it
    assert_pend_has_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.cnt != '0);

endmodule

// File: rtl/cmdq_front.sv
module cmdq_front
    import cmdq_pkg::*;
#(
    parameter bit ENHANCED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             wr_en_i,
    input  logic [CMD_W-1:0] wr_data_i,
    input  logic             pop_i,
    output logic             start_o,
    output logic             illegal_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             gross_err_o,
    output logic             chip_rst_o,
    output logic             bus_rst_o,
    output logic             flush_o,
    output logic             atn_o,
    output logic [CNT_W-1:0] q_count_o
);

    logic [CMD_W-1:0] head;
    logic [CNT_W-1:0] cnt;
    logic             pend, acc_chip, acc_bus, drop_full;
    logic             legal, self_done, is_flush, is_atn;
    logic             self_pop, kill, go;
    evt_t             ev_d, ev_q;

    cmdq_legal #(.ENHANCED(ENHANCED)) u_legal (
        .code_i      (head[CODE_W-1:0]),
        .mode_i      (mode_i),
        .legal_o     (legal),
        .self_done_o (self_done),
        .is_flush_o  (is_flush),
        .is_atn_o    (is_atn)
    );

    assign self_pop = pend && self_done;

    cmdq_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .ext_pop_i   (pop_i),
        .self_pop_i  (self_pop),
        .head_o      (head),
        .cnt_o       (cnt),
        .pend_o      (pend),
        .acc_chip_o  (acc_chip),
        .acc_bus_o   (acc_bus),
        .drop_full_o (drop_full)
    );

    always_comb begin
        kill          = acc_chip || acc_bus;
        go            = pend && !kill;
        ev_d          = '0;
        ev_d.start    = go && legal;
        ev_d.illegal  = go && !legal;
        ev_d.flush    = go && legal && is_flush;
        ev_d.atn      = go && legal && is_atn;
        ev_d.gross    = drop_full;
        ev_d.chip_rst = acc_chip;
        ev_d.bus_rst  = acc_bus;
        ev_d.cmd      = go ? head : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign start_o     = ev_q.start;
    assign illegal_o   = ev_q.illegal;
    assign cmd_o       = ev_q.cmd;
    assign gross_err_o = ev_q.gross;
    assign chip_rst_o  = ev_q.chip_rst;
    assign bus_rst_o   = ev_q.bus_rst;
    assign flush_o     = ev_q.flush;
    assign atn_o       = ev_q.atn;
    assign q_count_o   = cnt;

    // R5: a launch is either started or refused, never both
    assert_launch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, illegal_o}));

    // R9: flush strobe only accompanies a started flush code
    assert_flush_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (start_o && cmd_o[CODE_W-1:0] == OP_FLUSH));

    // R10: attention only raised from initiator mode
    assert_atn_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        atn_o |-> (start_o && $past(mode_i) == MODE_INIT));

    // R8: a reset strobe comes with an empty queue
    assert_rst_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst_o || bus_rst_o) |-> (q_count_o == '0 && !start_o && !illegal_o));

endmodule

// File: tb/cmdq_front_test.sv
`timescale 1ns/1ps
module cmdq_front_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pop = 1'b0;

    logic       st_b, il_b, ge_b, cr_b, br_b, fl_b, at_b;
    logic [7:0] cmd_b;
    logic [1:0] cnt_b;
    logic       st_e, il_e, ge_e, cr_e, br_e, fl_e, at_e;
    logic [7:0] cmd_e;
    logic [1:0] cnt_e;

    int  nchk = 0;
    int  nbad = 0;
    bit  done = 1'b0;
    logic [10:0] exp_b[$];
    logic [10:0] exp_e[$];

    always #2.5 clk = ~clk;

    cmdq_front #(.ENHANCED(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .pop_i(pop), .start_o(st_b), .illegal_o(il_b),
        .cmd_o(cmd_b), .gross_err_o(ge_b), .chip_rst_o(cr_b), .bus_rst_o(br_b),
        .flush_o(fl_b), .atn_o(at_b), .q_count_o(cnt_b)
    );

    cmdq_front #(.ENHANCED(1'b1)) uut_enh (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .pop_i(pop), .start_o(st_e), .illegal_o(il_e),
        .cmd_o(cmd_e), .gross_err_o(ge_e), .chip_rst_o(cr_e), .bus_rst_o(br_e),
        .flush_o(fl_e), .atn_o(at_e), .q_count_o(cnt_e)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // kinds: 1 start, 2 illegal, 3 gross, 4 chip reset, 5 bus reset, 6 flush, 7 atn
    task automatic push_exp(input bit enh, input int kind, input logic [7:0] c);
        logic [10:0] it;
        it = {kind[2:0], (kind <= 2) ? c : 8'h00};
        if (enh) exp_e.push_back(it);
        else     exp_b.push_back(it);
    endtask

    task automatic push_both(input int kind, input logic [7:0] c);
        push_exp(1'b0, kind, c);
        push_exp(1'b1, kind, c);
    endtask

    task automatic mon_one(input bit enh, input logic [6:0] fl, input logic [7:0] c);
        logic [10:0] it, ex;
        for (int k = 1; k <= 7; k++) begin
            if (fl[k-1]) begin
                it = {3'(k), (k <= 2) ? c : 8'h00};
                if ((enh ? exp_e.size() : exp_b.size()) == 0) begin
                    chk(1'b0, enh ? "scoreboard enh R3/R4" : "scoreboard base R3", it, 0);
                end else begin
                    ex = enh ? exp_e.pop_front() : exp_b.pop_front();
                    chk(it == ex, enh ? "event enh R2-order" : "event base R2-order", it, ex);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon_one(1'b0, {at_b, fl_b, br_b, cr_b, ge_b, il_b, st_b}, cmd_b);
            mon_one(1'b1, {at_e, fl_e, br_e, cr_e, ge_e, il_e, st_e}, cmd_e);
        end
    end

    function automatic bit legal_m(input logic [6:0] c, input int md, input bit enh);
        int g = c[6:4];
        int s = c[3:0];
        case (g)
            0: return (s <= 3) || (enh && md == 2 && s == 4);
            1: return md == 1 && (s <= 2 || s == 8 || s == 10 || (enh && s == 11));
            2: return md == 2 && s <= 11 && s != 6;
            4: return md == 0 && s <= (enh ? 6 : 5);
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c);
        wr_en = 1'b1; wr_data = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({st_b, il_b, ge_b, cr_b, br_b, fl_b, at_b} == 0 && cmd_b == 0, "R1 base strobes",
            {st_b, il_b, ge_b, cr_b, br_b, fl_b, at_b}, 0);
        chk({st_e, il_e, ge_e, cr_e, br_e, fl_e, at_e} == 0 && cmd_e == 0, "R1 enh strobes",
            {st_e, il_e, ge_e, cr_e, br_e, fl_e, at_e}, 0);
        chk(cnt_b == 0 && cnt_e == 0, "R1 count", cnt_b, 0);

        // R2: launch latency from a write into an empty queue
        mode = 2'd0;
        push_both(1, 8'h41);
        wr(8'h41);
        chk(cnt_b == 1, "R2 count after write", cnt_b, 1);
        chk(st_b == 0, "R2 no start yet", st_b, 0);
        @(negedge clk);
        chk(st_b == 1 && cmd_b == 8'h41, "R2 start one edge later", cmd_b, 8'h41);
        @(negedge clk);
        chk(st_b == 0, "R2 single-cycle strobe", st_b, 0);
        do_pop();
        chk(cnt_b == 0, "R7 pop empties", cnt_b, 0);

        // R3 R4 R5 R9 R10 R11 R12: sweep every non-reset code in each mode
        for (int md = 0; md < 3; md++) begin
            mode = md[1:0];
            @(negedge clk);
            for (int code = 0; code < 128; code++) begin
                logic [7:0] c;
                if (code == 2 || code == 3) continue;
                c = {code[0] ^ code[3], code[6:0]}; // R11: mix in bit 7
                for (int e = 0; e < 2; e++) begin
                    if (legal_m(code[6:0], md, e[0])) begin
                        push_exp(e[0], 1, c);
                        if (code == 1)    push_exp(e[0], 6, 8'h00);
                        if (code == 'h1A) push_exp(e[0], 7, 8'h00);
                    end else begin
                        push_exp(e[0], 2, c);
                    end
                end
                wr(c);
                idle(2);
                do_pop(); // R7: harmless if the command already left
                idle(1);
                chk(cnt_b == 0 && cnt_e == 0, "R5 R9 queue drained", {cnt_b, cnt_e}, 0);
            end
        end

        // R6 R7: fill, overflow, then pop through
        mode = 2'd1;
        @(negedge clk);
        push_both(1, 8'h10);
        push_both(3, 8'h00);
        wr_en = 1'b1; wr_data = 8'h10; @(negedge clk);
        wr_data = 8'h11; @(negedge clk);
        wr_data = 8'h12; @(negedge clk);
        wr_en = 1'b0;
        chk(ge_b == 1 && ge_e == 1, "R6 gross error on third write", ge_b, 1);
        chk(cnt_b == 2, "R6 count held at two", cnt_b, 2);
        idle(2);
        do_pop();
        chk(cnt_b == 1 && st_b == 0, "R7 promoted not yet launched", cnt_b, 1);
        push_both(1, 8'h11);
        do_pop(); // R7: ignored, head not launched yet
        chk(cnt_b == 1 && st_b == 1 && cmd_b == 8'h11, "R7 promoted head launched", cmd_b, 8'h11);
        do_pop();
        chk(cnt_b == 0, "R7 queue empty", cnt_b, 0);
        do_pop();
        chk(cnt_b == 0, "R7 pop on empty ignored", cnt_b, 0);

        // R9 R10: self-completing codes chain
        push_both(1, 8'h00);
        push_both(1, 8'h1A);
        push_both(7, 8'h00);
        wr_en = 1'b1; wr_data = 8'h00; @(negedge clk);
        wr_data = 8'h1A; @(negedge clk);
        wr_en = 1'b0;
        chk(st_b == 1 && cmd_b == 8'h00, "R9 no-op started", cmd_b, 8'h00);
        @(negedge clk);
        chk(at_b == 1 && cmd_b == 8'h1A, "R10 chained set-attention", cmd_b, 8'h1A);
        idle(1);
        chk(cnt_b == 0 && cnt_e == 0, "R9 R10 chain drained", cnt_b, 0);

        // R8: bus reset with one launched command queued
        push_both(1, 8'h10);
        wr(8'h10);
        idle(2);
        push_both(5, 8'h00);
        wr(8'h03);
        chk(br_b == 1 && cnt_b == 0, "R8 bus reset empties", cnt_b, 0);
        do_pop();
        chk(cnt_b == 0, "R8 pop after reset ignored", cnt_b, 0);

        // R6: reset code against a full queue is dropped
        push_both(1, 8'h10);
        push_both(3, 8'h00);
        wr_en = 1'b1; wr_data = 8'h10; @(negedge clk);
        wr_data = 8'h11; @(negedge clk);
        wr_data = 8'h82; @(negedge clk);
        wr_en = 1'b0;
        chk(cr_b == 0 && cnt_b == 2, "R6 reset dropped when full", cnt_b, 2);
        do_pop();
        push_both(1, 8'h11);
        idle(1);
        do_pop();

        // R8: chip reset preempts a launch due at the same edge
        push_both(4, 8'h00);
        wr_en = 1'b1; wr_data = 8'h10; @(negedge clk);
        wr_data = 8'h02; @(negedge clk);
        wr_en = 1'b0;
        chk(cr_b == 1 && st_b == 0 && cnt_b == 0, "R8 chip reset preempts", {cr_b, st_b}, 2);
        idle(3);

        while (exp_b.size() > 0) begin
            chk(1'b0, "base missing event", 0, exp_b.pop_front());
        end
        while (exp_e.size() > 0) begin
            chk(1'b0, "enh missing event", 0, exp_e.pop_front());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule